// File: doc/BRIEF.md
# Memory Fill Write Generator

This block writes a test sequence into a word-addressed memory through a plain write-command port. The port carries valid, ready, a word address and a data word. Software supplies three byte quantities: a base address, an end address and a length. It then pulses start. The block converts these into word terms and issues one write per word. It raises done once the final write has been taken.

By default the data is a running counter and the address walks upward from the base. Two independent options replace either or both with the state of a 23-bit linear-feedback shift register. The address offset is confined to a window whose size is the distance from base to end. That size must be a power of two, because the wrap is done by masking the offset.

The configuration inputs are latched when start is taken. They may change during a run without effect.

Top module: `mem_fill_gen`

## Requirements
- R1: A run issues exactly len/(DATA_W/8) accepted writes. In sequential address mode, write i goes to word base/(DATA_W/8) + i before any wrap.
- R2: In counter data mode, the data of write i is i. The first write carries 0 and each accepted write raises the value by one.
- R3: The offset of write i is masked with W−1, where W = (end−base)/(DATA_W/8) words and W is a power of two. Words outside [base/(DATA_W/8), base/(DATA_W/8)+W) keep their contents, and a later write to a word overwrites an earlier one.
- R4: The pseudo-random state is 23 bits wide and set to 1 at start. It advances once per accepted write to {s[21:0], s[22]^s[17]}. In random data mode, write i carries the zero-extended state after i advances, so no value repeats within a run and the values do not count upward.
- R5: In random address mode, the offset of write i is that same state masked with W−1. The data stays the counter unless random data mode is also set, so every value written is below the word count.
- R6: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold their values. The block advances only on a cycle where both are high.
- R7: done rises in the cycle after the last write is accepted, and wr_valid is low from then on. done stays high until the next start or reset.
- R8: A start with a length below one word sets done in the next cycle and issues no write.
- R9: start is ignored while run is low. Dropping run during a run lowers wr_valid in the next cycle, and done stays low.
- R10: After reset, wr_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enable; low ignores start and aborts a run |
| start | input | 1 | One-cycle pulse that latches configuration and begins a run |
| base | input | ADDR_W | Byte base address |
| lim | input | ADDR_W | Byte end address of the wrap window |
| len | input | ADDR_W | Byte length to write |
| rand_data | input | 1 | Use pseudo-random data instead of the counter |
| rand_addr | input | 1 | Use pseudo-random offsets instead of sequential ones |
| done | output | 1 | Run complete; sticky until start or reset |
| wr_valid | output | 1 | Write command valid |
| wr_ready | input | 1 | Memory accepts the write command |
| wr_addr | output | ADDR_W | Word address of the write |
| wr_data | output | DATA_W | Write data |

## Verification
The hardest case to reach is a stall that lands exactly on the final write of a wrapped run. In that case the overwrite order, the hold under backpressure and the done timing all have to agree. The bench sweeps base, window size, length and both random options, and runs each combination with and without a ready pattern that stalls every third cycle. Stalls therefore fall on every write position, including the last one. A memory model in the bench receives the accepted writes, and the whole region is compared against an arithmetic model that applies the overwrites in order.

// File: rtl/mem_fill_gen.sv
module mem_fill_gen #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] lim,
  input  logic [ADDR_W-1:0] len,
  input  logic              rand_data,
  input  logic              rand_addr,
  output logic              done,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int BYTES = DATA_W / 8;
  localparam int SH    = $clog2(BYTES);
  localparam int LW    = 23;

  logic              busy;
  logic              rd_q, ra_q;
  logic [ADDR_W-1:0] base_q, mask_q, words_q, cnt, off;
  logic [LW-1:0]     lfsr;

  wire [ADDR_W-1:0] in_words = len >> SH;
  wire [ADDR_W-1:0] span     = (lim - base) >> SH;
  wire              fire     = busy & wr_ready;
  wire              last     = (cnt == words_q - 1'b1);
  wire [LW-1:0]     lfsr_nx  = {lfsr[LW-2:0], lfsr[22] ^ lfsr[17]};

  assign off      = ra_q ? ADDR_W'(lfsr) : cnt;
  assign wr_valid = busy;
  assign wr_addr  = base_q + (off & mask_q);
  assign wr_data  = rd_q ? DATA_W'(lfsr) : DATA_W'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      lfsr    <= LW'(1);
      base_q  <= '0;
      mask_q  <= '0;
      words_q <= '0;
      rd_q    <= 1'b0;
      ra_q    <= 1'b0;
    end else if (start && run) begin
      base_q  <= base >> SH;
      mask_q  <= span - 1'b1;
      words_q <= in_words;
      rd_q    <= rand_data;
      ra_q    <= rand_addr;
      cnt     <= '0;
      lfsr    <= LW'(1);
      busy    <= (in_words != '0);
      done    <= (in_words == '0);
    end else if (!run) begin
      busy <= 1'b0;
    end else if (fire) begin
      cnt  <= cnt + 1'b1;
      lfsr <= lfsr_nx;
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready && run && !start) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_valid);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  a_r8_zero_len: assert property (@(posedge clk) disable iff (rst)
    (start && run && in_words == '0) |=> (done && !wr_valid));

  a_r9_abort: assert property (@(posedge clk) disable iff (rst)
    (!run && !done) |=> (!wr_valid && !done));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (fire && !rd_q && !last && run && !start) |=>
      (wr_valid && wr_data == $past(wr_data) + DATA_W'(1)));

  a_r5_counter_bound: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && ra_q && !rd_q) |-> (wr_data < DATA_W'(words_q)));
endmodule

// File: tb/tb_mem_fill_gen.sv
module tb_mem_fill_gen;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int MW = 64;

  logic clk = 0, rst = 1, run = 0, start = 0, rand_data = 0, rand_addr = 0;
  logic [AW-1:0] base = 0, lim = 0, len = 0;
  logic done, wr_valid, wr_ready = 1;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  mem_fill_gen #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .run(run), .start(start), .base(base), .lim(lim),
    .len(len), .rand_data(rand_data), .rand_addr(rand_addr), .done(done),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  int nwr = 0, oob = 0, holdbad = 0, cyc = 0;
  bit stall_en = 0;
  logic [DW-1:0] mem [MW];
  logic [DW-1:0] expm [MW];
  logic [22:0] seq [64];
  logic prev_stall = 0;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_data;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    seq[0] = 23'd1;
    for (int i = 1; i < 64; i++) seq[i] = {seq[i-1][21:0], seq[i-1][22] ^ seq[i-1][17]};
  end

  always begin
    @(negedge clk);
    cyc++;
    wr_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
    #1;
    if (prev_stall && run && wr_valid && !start)
      if (wr_addr != prev_addr || wr_data != prev_data) holdbad++;
    prev_stall = wr_valid && !wr_ready;
    prev_addr  = wr_addr;
    prev_data  = wr_data;
    if (wr_valid && wr_ready) begin
      nwr++;
      if (wr_addr < MW) mem[wr_addr[5:0]] = wr_data; else oob++;
    end
  end

  task automatic fill(input int bw, input int span, input int lw, input bit rd, input bit ra);
    int idx, off;
    bit ok;
    for (int i = 0; i < MW; i++) begin mem[i] = '0; expm[i] = '0; end
    nwr = 0; oob = 0; holdbad = 0;
    for (int i = 0; i < lw; i++) begin
      off = ra ? int'(seq[i]) : i;
      idx = bw + (off & (span - 1));
      expm[idx] = rd ? DW'(seq[i]) : DW'(i);
    end
    @(negedge clk);
    base = AW'(bw * 4); lim = AW'((bw + span) * 4); len = AW'(lw * 4);
    rand_data = rd; rand_addr = ra; run = 1; start = 1;
    @(negedge clk);
    start = 0;
    if (lw == 0) begin
      chk(done === 1'b1 && wr_valid === 1'b0, "R8 zero length done", done, 1);
      @(negedge clk);
      chk(nwr == 0, "R8 no writes", nwr, 0);
      return;
    end
    for (int t = 0; t < 400 && done !== 1'b1; t++) @(negedge clk);
    #2;
    chk(nwr == lw && oob == 0, "R1 write count", nwr, lw);
    ok = 1;
    for (int i = 0; i < MW; i++) if (mem[i] !== expm[i]) ok = 0;
    chk(ok, rd ? "R4 random data image" : (ra ? "R5 random address image" : "R3 R2 window image"), ok, 1);
    chk(holdbad == 0, "R6 hold under stall", holdbad, 0);
    chk(done === 1'b1 && wr_valid === 1'b0, "R7 done and idle", wr_valid, 0);
  endtask

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lens [6] = '{0, 1, 3, 5, 16, 24};
    int bases [3] = '{0, 1, 4};
    bit uniq;
    repeat (3) @(negedge clk);
    #1;
    chk(wr_valid === 1'b0 && done === 1'b0, "R10 reset state", {wr_valid, done}, 0);
    rst = 0;

    // R1 R2 R3 R4 R5 R6 R7 R8 sweep
    for (int m = 0; m < 8; m++)
      for (int bi = 0; bi < 3; bi++)
        for (int si = 0; si < 5; si++)
          for (int li = 0; li < 6; li++) begin
            stall_en = m[2];
            fill(bases[bi], 1 << si, lens[li], m[0], m[1]);
          end
    stall_en = 0;

    // R4 uniqueness and non-counting
    fill(0, 32, 32, 1'b1, 1'b0);
    uniq = 1;
    for (int i = 0; i < 32; i++)
      for (int j = i + 1; j < 32; j++) if (mem[i] == mem[j]) uniq = 0;
    chk(uniq, "R4 no repeated value", uniq, 1);
    chk(!(mem[1] == mem[0] + 1 && mem[2] == mem[1] + 1), "R4 not incrementing", mem[1], 0);

    // R7 done sticky
    repeat (4) @(negedge clk);
    chk(done === 1'b1, "R7 done sticky", done, 1);

    // R9 start ignored while run low
    run = 0; start = 1; len = 32'd64;
    @(negedge clk); start = 0;
    @(negedge clk);
    chk(wr_valid === 1'b0 && done === 1'b1, "R9 start ignored", wr_valid, 0);

    // R9 abort
    run = 1; start = 1; base = 0; lim = 32'd64; len = 32'd64;
    @(negedge clk); start = 0;
    chk(done === 1'b0 && wr_valid === 1'b1, "R7 done cleared by start", done, 0);
    repeat (3) @(negedge clk);
    run = 0;
    @(negedge clk);
    chk(wr_valid === 1'b0 && done === 1'b0, "R9 abort", {wr_valid, done}, 0);

    // R10 reset mid-run
    run = 1; start = 1;
    @(negedge clk); start = 0; rst = 1;
    @(negedge clk); rst = 0;
    chk(wr_valid === 1'b0 && done === 1'b0, "R10 reset clears", {wr_valid, done}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule